// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block holds the running source address, destination address and remaining transfer count of one DMA channel, and advances them one step for every beat the bus side accepts. Source and destination each have their own stepping mode (up, down or held) and their own transfer width, and each step moves the address by the width in bytes. The count is kept in source-width transfers.

A channel is armed with a single-cycle load that captures the start addresses, widths, modes, a burst code and a transfer size. Once the channel has issued 2^burst_code beats it stops and raises a re-arbitration request. The request stays up until the arbiter returns a resume. When the last beat is accepted, the count reads zero, both address registers keep the ending addresses, and a one-cycle done pulse follows. An abort freezes everything where it stands and gives no done pulse.

Top module: `dma_addr_seq`

## Requirements
- R1: A load with a nonzero size while idle makes, one cycle later, `busy_o`=1, `count_o`=size and both addresses equal to their start values.
- R2: Each address steps independently on every accepted beat. Mode code 0 adds the step, code 1 subtracts it, and codes 2 and 3 leave the address unchanged.
- R3: The step for each address is 2^width bytes, using that side's own width code in the range 0 to 5.
- R4: Each accepted beat lowers `count_o` by one. A beat is ignored while the channel is idle or while it waits for re-arbitration.
- R5: After 2^burst_code accepted beats with count still nonzero, `burst_req_o` rises one cycle after the last beat of the burst. Beats are then ignored until `resume_i` arrives, and `resume_i` only clears the request.
- R6: The final beat drives `count_o` to 0 and `busy_o` low, and `done_o` goes high for exactly one cycle afterwards. Both addresses keep their ending values. If the final beat also closes a burst, done is raised and no re-arbitration request is made.
- R7: An abort while busy clears `busy_o` and `burst_req_o` on the next edge, freezes the addresses and the count, and produces no done pulse. Abort takes precedence over a beat in the same cycle.
- R8: Addresses are `ADDR_W` bits wide, stored as a low 32-bit half plus an upper half that exists only when `ADDR_W` exceeds 32. Carries and borrows cross between the halves.
- R9: A load with zero size, or a load while busy, changes nothing.
- R10: After reset, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Arm the channel with the configuration inputs |
| src_start_i | input | ADDR_W | Source start address |
| dst_start_i | input | ADDR_W | Destination start address |
| src_width_i | input | 3 | Source width code (bytes = 2^code) |
| dst_width_i | input | 3 | Destination width code |
| src_mode_i | input | 2 | Source stepping mode: 0 up, 1 down, 2/3 held |
| dst_mode_i | input | 2 | Destination stepping mode |
| burst_code_i | input | 4 | Beats per burst = 2^code |
| xfer_size_i | input | CNT_W | Transfer size in source transfers |
| beat_i | input | 1 | Bus side accepted one beat |
| resume_i | input | 1 | Re-arbitration granted, continue |
| abort_i | input | 1 | Stop the channel in place |
| src_addr_o | output | ADDR_W | Current source address |
| dst_addr_o | output | ADDR_W | Current destination address |
| count_o | output | CNT_W | Remaining transfers |
| busy_o | output | 1 | Channel active |
| burst_req_o | output | 1 | Waiting for re-arbitration |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The end of a burst and the end of the transfer can land on the same beat. The bench forces this by choosing a size that is an exact multiple of the burst length, with the burst code set so that the final beat closes a burst. The behavioural model expects done and no request, and every clock compares it against `burst_req_o` and `done_o`. A second coincidence is an abort asserted together with a beat. There the bench expects the addresses and the count to stay exactly at their values before that beat.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    AM_INC = 2'd0,
    AM_DEC = 2'd1,
    AM_FIX = 2'd2,
    AM_RSV = 2'd3
  } addr_mode_e;

  localparam int unsigned WCODE_W = 3;
  localparam int unsigned BCODE_W = 4;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 40
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  start_i,
  input  logic [1:0]         mode_i,
  input  logic [WCODE_W-1:0] width_i,
  input  logic               step_i,
  output logic [ADDR_W-1:0]  addr_o
);
  localparam int unsigned LO_W = (ADDR_W > 32) ? 32 : ADDR_W;
  localparam int unsigned HI_W = (ADDR_W > 32) ? ADDR_W - 32 : 1;

  addr_mode_e         mode_q;
  logic [WCODE_W-1:0] width_q;
  logic [ADDR_W-1:0]  step_bytes, next_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= AM_INC;
      width_q <= '0;
    end else if (load_i) begin
      mode_q  <= addr_mode_e'(mode_i);
      width_q <= width_i;
    end
  end

  always_comb begin
    step_bytes = ADDR_W'(1) << width_q;
    unique case (mode_q)
      AM_INC:  next_addr = addr_o + step_bytes;
      AM_DEC:  next_addr = addr_o - step_bytes;
      default: next_addr = addr_o;
    endcase
  end

  // split storage: upper half only exists for wide address spaces
  generate
    if (ADDR_W > 32) begin : g_split
      logic [LO_W-1:0] lo_q;
      logic [HI_W-1:0] hi_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (load_i) begin
          lo_q <= start_i[LO_W-1:0];
          hi_q <= start_i[ADDR_W-1:LO_W];
        end else if (step_i) begin
          lo_q <= next_addr[LO_W-1:0];
          hi_q <= next_addr[ADDR_W-1:LO_W];
        end
      end
      assign addr_o = {hi_q, lo_q};
    end else begin : g_flat
      logic [ADDR_W-1:0] a_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      a_q <= '0;
        else if (load_i)  a_q <= start_i;
        else if (step_i)  a_q <= next_addr;
      end
      assign addr_o = a_q;
    end
  endgenerate

  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !step_i) |=> $stable(addr_o));
  assert_fixed_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && step_i && (mode_q == AM_FIX || mode_q == AM_RSV)) |=> $stable(addr_o));
endmodule

// File: rtl/dma_beat_ctrl.sv
module dma_beat_ctrl
  import dma_seq_pkg::*;
#(
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned MAX_BURST_CODE = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BCODE_W-1:0] burst_code_i,
  input  logic [CNT_W-1:0]   size_i,
  input  logic               beat_i,
  input  logic               resume_i,
  input  logic               abort_i,
  output logic               load_ok_o,
  output logic               step_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               busy_o,
  output logic               burst_req_o,
  output logic               done_o
);
  localparam int unsigned BCNT_W = MAX_BURST_CODE + 1;

  logic [CNT_W-1:0]   cnt_q;
  logic [BCNT_W-1:0]  bcnt_q;
  logic [BCODE_W-1:0] code_q;
  logic               busy_q, hold_q, done_q;
  logic               kill, last_beat, burst_end;

  assign kill      = abort_i && busy_q;
  assign load_ok_o = load_i && !busy_q && (size_i != '0);
  assign step_o    = busy_q && !hold_q && beat_i && !abort_i;
  assign last_beat = (cnt_q == CNT_W'(1));
  assign burst_end = (bcnt_q == ((BCNT_W'(1) << code_q) - BCNT_W'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bcnt_q <= '0;
      code_q <= '0;
      busy_q <= 1'b0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (kill) begin
        busy_q <= 1'b0;
        hold_q <= 1'b0;
      end else if (load_ok_o) begin
        cnt_q  <= size_i;
        code_q <= burst_code_i;
        bcnt_q <= '0;
        busy_q <= 1'b1;
        hold_q <= 1'b0;
      end else if (hold_q) begin
        if (resume_i) hold_q <= 1'b0;
      end else if (step_o) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_beat) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else if (burst_end) begin
          hold_q <= 1'b1;
          bcnt_q <= '0;
        end else begin
          bcnt_q <= bcnt_q + BCNT_W'(1);
        end
      end
    end
  end

  assign count_o     = cnt_q;
  assign busy_o      = busy_q;
  assign burst_req_o = hold_q;
  assign done_o      = done_q;

  assert_done_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (count_o == '0 && !busy_o));
  assert_done_not_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && burst_req_o));
  assert_abort_stop_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && busy_o) |=> (!busy_o && !burst_req_o && !done_o && $stable(count_o)));
  assert_req_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_req_o |-> busy_o);
  assert_hold_count_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_req_o && !abort_i) |=> $stable(count_o));
endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq
  import dma_seq_pkg::*;
#(
  parameter int unsigned ADDR_W         = 40,
  parameter int unsigned CNT_W          = 16,
  parameter int unsigned MAX_BURST_CODE = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  src_start_i,
  input  logic [ADDR_W-1:0]  dst_start_i,
  input  logic [2:0]         src_width_i,
  input  logic [2:0]         dst_width_i,
  input  logic [1:0]         src_mode_i,
  input  logic [1:0]         dst_mode_i,
  input  logic [3:0]         burst_code_i,
  input  logic [CNT_W-1:0]   xfer_size_i,
  input  logic               beat_i,
  input  logic               resume_i,
  input  logic               abort_i,
  output logic [ADDR_W-1:0]  src_addr_o,
  output logic [ADDR_W-1:0]  dst_addr_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               busy_o,
  output logic               burst_req_o,
  output logic               done_o
);
  logic load_ok, step;

  dma_beat_ctrl #(.CNT_W(CNT_W), .MAX_BURST_CODE(MAX_BURST_CODE)) u_ctrl (
    .clk_i, .rst_ni, .load_i,
    .burst_code_i, .size_i(xfer_size_i),
    .beat_i, .resume_i, .abort_i,
    .load_ok_o(load_ok), .step_o(step),
    .count_o, .busy_o, .burst_req_o, .done_o
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_src (
    .clk_i, .rst_ni, .load_i(load_ok), .start_i(src_start_i),
    .mode_i(src_mode_i), .width_i(src_width_i), .step_i(step), .addr_o(src_addr_o)
  );

  dma_addr_step #(.ADDR_W(ADDR_W)) u_dst (
    .clk_i, .rst_ni, .load_i(load_ok), .start_i(dst_start_i),
    .mode_i(dst_mode_i), .width_i(dst_width_i), .step_i(step), .addr_o(dst_addr_o)
  );

  assert_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !busy_o && xfer_size_i != '0) |=> (busy_o && count_o == $past(xfer_size_i)));
  assert_busy_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && busy_o && !beat_i && !abort_i) |=> ($stable(count_o) && $stable(src_addr_o)));
endmodule

// File: tb/dma_addr_seq_tb_top.sv
module dma_addr_seq_tb_top;
  localparam int AW = 40;
  localparam int CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic load = 0, beat = 0, resume = 0, abort = 0;
  logic [AW-1:0] src_s = '0, dst_s = '0;
  logic [2:0] sw = 0, dw = 0;
  logic [1:0] sm = 0, dm = 0;
  logic [3:0] bc = 0;
  logic [CW-1:0] size = 0;
  logic [AW-1:0] src_a, dst_a;
  logic [CW-1:0] cnt;
  logic busy, breq, done;

  int checks = 0, fails = 0, cyc = 0;
  bit saw_req = 0, saw_done = 0;

  always #2 clk = ~clk;

  dma_addr_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load),
    .src_start_i(src_s), .dst_start_i(dst_s),
    .src_width_i(sw), .dst_width_i(dw), .src_mode_i(sm), .dst_mode_i(dm),
    .burst_code_i(bc), .xfer_size_i(size),
    .beat_i(beat), .resume_i(resume), .abort_i(abort),
    .src_addr_o(src_a), .dst_addr_o(dst_a), .count_o(cnt),
    .busy_o(busy), .burst_req_o(breq), .done_o(done)
  );

  // behavioural reference model
  logic [AW-1:0] m_src = '0, m_dst = '0;
  int m_cnt = 0, m_bcnt = 0, m_blen = 1, m_sw = 0, m_dw = 0, m_sm = 0, m_dm = 0;
  bit m_busy = 0, m_hold = 0, m_done = 0;

  function automatic logic [AW-1:0] adv(logic [AW-1:0] a, int mode, int w);
    logic [AW-1:0] s = AW'(1) << w;
    if (mode == 0) return a + s;
    if (mode == 1) return a - s;
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = '0; m_dst = '0; m_cnt = 0; m_bcnt = 0;
      m_busy = 0; m_hold = 0; m_done = 0;
    end else begin
      m_done = 0;
      if (abort && m_busy) begin
        m_busy = 0; m_hold = 0;
      end else if (load && !m_busy && size != 0) begin
        m_src = src_s; m_dst = dst_s; m_cnt = int'(size);
        m_sw = sw; m_dw = dw; m_sm = sm; m_dm = dm;
        m_blen = 1 << bc; m_bcnt = 0; m_busy = 1; m_hold = 0;
      end else if (m_hold) begin
        if (resume) m_hold = 0;
      end else if (m_busy && beat) begin
        m_src = adv(m_src, m_sm, m_sw);
        m_dst = adv(m_dst, m_dm, m_dw);
        m_cnt--;
        m_bcnt++;
        if (m_cnt == 0) begin m_busy = 0; m_done = 1; end
        else if (m_bcnt == m_blen) begin m_hold = 1; m_bcnt = 0; end
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (breq) saw_req = 1;
      if (done) saw_done = 1;
      chk(src_a == m_src, "R2 src_addr", src_a, m_src);
      chk(dst_a == m_dst, "R3 dst_addr", dst_a, m_dst);
      chk(int'(cnt) == m_cnt, "R4 count", cnt, m_cnt);
      chk(breq == m_hold, "R5 burst_req", breq, m_hold);
      chk(done == m_done, "R6 done", done, m_done);
      chk(busy == m_busy, "R1 busy", busy, m_busy);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic arm(logic [AW-1:0] s, logic [AW-1:0] d, int sw_, int dw_, int sm_, int dm_,
                     int bc_, int sz);
    @(negedge clk);
    src_s = s; dst_s = d; sw = 3'(sw_); dw = 3'(dw_); sm = 2'(sm_); dm = 2'(dm_);
    bc = 4'(bc_); size = CW'(sz); load = 1;
    @(negedge clk);
    load = 0;
  endtask

  // stream beats, answering re-arbitration one cycle later
  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      beat = 1;
      resume = breq;
    end
    @(negedge clk);
    beat = 0; resume = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(src_a == 0 && dst_a == 0 && cnt == 0 && !busy && !breq && !done, "R10 reset", cnt, 0);
    rst_n = 1;

    // up/down, burst of 2, size 5
    arm(40'h10, 40'h1000, 2, 0, 0, 1, 1, 5);
    chk(busy && cnt == 5 && src_a == 40'h10, "R1 armed", cnt, 5);
    saw_req = 0; saw_done = 0;
    run(14);
    chk(src_a == 40'h24, "R3 src end", src_a, 40'h24);
    chk(dst_a == 40'hFFB, "R2 dst end", dst_a, 40'hFFB);
    chk(cnt == 0 && saw_done && saw_req, "R6 count done", cnt, 0);

    // burst end coincides with final beat; fixed and reserved modes
    arm(40'h200, 40'h300, 5, 3, 2, 3, 2, 4);
    saw_req = 0; saw_done = 0;
    run(6);
    chk(!saw_req && saw_done, "R6 no req at final", saw_req, 0);
    chk(src_a == 40'h200 && dst_a == 40'h300, "R2 fixed", src_a, 40'h200);

    // carry and borrow across the 32-bit halves
    arm(40'h00_FFFF_FFFC, 40'h01_0000_0000, 2, 0, 0, 1, 3, 4);
    run(6);
    chk(src_a == 40'h01_0000_000C, "R8 carry", src_a, 40'h01_0000_000C);
    chk(dst_a == 40'h00_FFFF_FFFC, "R8 borrow", dst_a, 40'h00_FFFF_FFFC);

    // beats while idle are ignored
    run(3);
    chk(cnt == 0 && src_a == 40'h01_0000_000C, "R4 idle beat", cnt, 0);

    // zero-size load ignored
    arm(40'h5000, 40'h6000, 0, 0, 0, 0, 0, 0);
    chk(!busy && src_a == 40'h01_0000_000C, "R9 zero size", busy, 0);

    // abort with beat, then load while busy
    arm(40'h800, 40'h900, 1, 1, 0, 0, 4, 10);
    run(3);
    arm(40'hAAA0, 40'hBBB0, 0, 0, 0, 0, 0, 7);
    chk(cnt == 7 && src_a == 40'h806, "R9 busy load", cnt, 7);
    @(negedge clk); beat = 1; abort = 1;
    @(negedge clk); beat = 0; abort = 0;
    saw_done = 0;
    chk(!busy && !breq && cnt == 7 && src_a == 40'h806 && dst_a == 40'h906, "R7 frozen", src_a, 40'h806);
    run(3);
    chk(!saw_done && cnt == 7, "R7 no done", cnt, 7);

    repeat (2) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule